// File: doc/BRIEF.md
# Vertex Shader Result Writeback Unit

This unit sits at the end of a vertex shader execution pipe. Each cycle it takes the four-component result vectors of the multiply-accumulate path and the special-function path. Using the destination fields already decoded from the instruction, it commits those results to a temporary register file and an output register file. A temporary index chooses the temporary register. Each path has its own 4-bit component mask for temporaries. A separate output index, qualified by a select bit and an overall mask, chooses an output register, and a mux bit picks which path feeds it.

A start-of-vertex strobe returns every output register to the homogeneous default (0, 0, 0, 1.0). The output position register (output 0) is also visible as temporary 12, so operand fetch can read it back like any temporary. Two combinational read ports, one for temporaries and one for outputs, serve operand fetch and the consumer of the finished vertex.

Vectors are packed with X in the top 32 bits, then Y and Z, with W in the bottom 32 bits. Mask bit 3 is X and mask bit 0 is W, so each mask bit lines up with its lane.

Top module: `vswb_top`

## Requirements
- R1: After reset every temporary reads as zero and every output register reads as X=Y=Z=0x00000000, W=0x3F800000.
- R2: Mask bit 3 selects lane X (vector bits 127:96), bit 2 Y (95:64), bit 1 Z (63:32) and bit 0 W (31:0); a lane whose mask bit is 0 keeps its old value.
- R3: For a temporary index below 12, each lane set in the MAC mask of temporary `tempIdx` takes the matching lane of `macResult`.
- R4: Each lane set in the ILU mask of that temporary takes the matching lane of `iluResult`; when both masks set the same lane, the ILU value is stored.
- R5: With `destSel`=1, output register `outIdx` takes, in each lane set in both `overallMask` and the selected unit's mask, the lane of the unit picked by `destMux` (0 = MAC, 1 = ILU).
- R6: With `destSel`=0, no output register changes.
- R7: An output index of 13 or above changes no output register.
- R8: A cycle with `vertexStart`=1 sets every output register to the default of R1 on the next cycle; an output write requested in that cycle is dropped, and temporary writes in that cycle still happen.
- R9: A read of temporary index 12 returns output register 0, including a value written by the previous cycle.
- R10: A temporary index of 12 to 15 changes no temporary; reads of temporary indices 13 to 15 and of output indices 13 or above return zero.
- R11: Both read ports are combinational from stored state: a write becomes visible in the cycle after its clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vertexStart | input | 1 | Start of a new vertex; restores output defaults |
| macResult | input | 128 | MAC path result vector |
| iluResult | input | 128 | ILU path result vector |
| macMask | input | 4 | MAC component mask (bit 3 = X) |
| iluMask | input | 4 | ILU component mask (bit 3 = X) |
| tempIdx | input | 4 | Destination temporary index |
| overallMask | input | 4 | Output-write component mask |
| destSel | input | 1 | 1 enables the output-register write |
| destMux | input | 1 | Output source: 0 = MAC, 1 = ILU |
| outIdx | input | 8 | Destination output register index |
| tempRdIdx | input | 4 | Temporary read index (12 = output position) |
| tempRdData | output | 128 | Temporary read data |
| outRdIdx | input | 8 | Output register read index |
| outRdData | output | 128 | Output register read data |
| posOut | output | 128 | Output position register (output 0) |

## Verification
The main write path is driven from a table of destination patterns. These include disjoint MAC and ILU masks, fully overlapping masks, single-lane masks on either end, and output writes sourced from each unit under an overall mask that is narrower and wider than the unit mask. After each pattern both full register files are compared, so a lane-order swap, a lost ILU priority or a wrong source mux each shows as a distinct lane mismatch. Directed cases then pit the start strobe against a concurrent output write. They also use the alias index 12 straight after a position write, the out-of-range indices on both files, and a same-cycle read that must still show the old value.

// File: rtl/vswb_pkg.sv
package vswb_pkg;
  localparam int LANES = 4;

  typedef struct packed {
    logic [LANES-1:0] tempMacEn;
    logic [LANES-1:0] tempIluEn;
    logic [LANES-1:0] outEn;
    logic             outFromIlu;
    logic             outClear;
  } wbStrobes_t;
endpackage

// File: rtl/vswb_ctrl.sv
module vswb_ctrl
  import vswb_pkg::*;
#(
  parameter int NUM_TEMP = 12,
  parameter int NUM_OUT  = 13,
  parameter int TIDX_W   = 4,
  parameter int OIDX_W   = 8
) (
  input  logic              vertexStart,
  input  logic [LANES-1:0]  macMask,
  input  logic [LANES-1:0]  iluMask,
  input  logic [TIDX_W-1:0] tempIdx,
  input  logic [LANES-1:0]  overallMask,
  input  logic              destSel,
  input  logic              destMux,
  input  logic [OIDX_W-1:0] outIdx,
  output wbStrobes_t        strobes
);
  logic tempHit;
  logic outHit;
  logic outGo;
  logic [LANES-1:0] unitMask;

  assign tempHit  = (int'(tempIdx) < NUM_TEMP);
  assign outHit   = (int'(outIdx) < NUM_OUT);
  assign outGo    = destSel && outHit && !vertexStart;
  assign unitMask = destMux ? iluMask : macMask;

  always_comb begin
    strobes            = '0;
    strobes.outClear   = vertexStart;
    strobes.outFromIlu = destMux;
    if (tempHit) begin
      // the ILU lane takes precedence, so the MAC lane is withheld where both hit
      strobes.tempIluEn = iluMask;
      strobes.tempMacEn = macMask & ~iluMask;
    end
    if (outGo) begin
      strobes.outEn = overallMask & unitMask;
    end
  end
endmodule

// File: rtl/vswb_datapath.sv
module vswb_datapath
  import vswb_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          NUM_TEMP  = 12,
  parameter int          NUM_OUT   = 13,
  parameter int          TIDX_W    = 4,
  parameter int          OIDX_W    = 8,
  parameter logic [31:0] ONE_VALUE = 32'h3F80_0000,
  localparam int         VEC_W     = LANES * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  wbStrobes_t        strobes,
  input  logic [VEC_W-1:0]  macResult,
  input  logic [VEC_W-1:0]  iluResult,
  input  logic [TIDX_W-1:0] tempIdx,
  input  logic [OIDX_W-1:0] outIdx,
  input  logic [TIDX_W-1:0] tempRdIdx,
  output logic [VEC_W-1:0]  tempRdData,
  input  logic [OIDX_W-1:0] outRdIdx,
  output logic [VEC_W-1:0]  outRdData,
  output logic [VEC_W-1:0]  posOut
);
  localparam int TSEL_W    = (NUM_TEMP > 1) ? $clog2(NUM_TEMP) : 1;
  localparam int OSEL_W    = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam int POS_ALIAS = NUM_TEMP;

  logic [VEC_W-1:0] tempRf [NUM_TEMP];
  logic [VEC_W-1:0] outRf  [NUM_OUT];
  logic [VEC_W-1:0] outSrc;
  logic [VEC_W-1:0] outDefault;
  logic [TSEL_W-1:0] tSel;
  logic [OSEL_W-1:0] oSel;

  // default vector: zero in X, Y, Z and 1.0 in W (the lowest lane)
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_default
      if (g == 0) begin : g_w
        assign outDefault[g*DATA_W +: DATA_W] = DATA_W'(ONE_VALUE);
      end else begin : g_xyz
        assign outDefault[g*DATA_W +: DATA_W] = '0;
      end
    end
  endgenerate

  assign outSrc = strobes.outFromIlu ? iluResult : macResult;
  assign tSel   = tempIdx[TSEL_W-1:0];
  assign oSel   = outIdx[OSEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_TEMP; t++) tempRf[t] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (strobes.tempMacEn[l]) tempRf[tSel][l*DATA_W +: DATA_W] <= macResult[l*DATA_W +: DATA_W];
        if (strobes.tempIluEn[l]) tempRf[tSel][l*DATA_W +: DATA_W] <= iluResult[l*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.outClear) begin
      for (int o = 0; o < NUM_OUT; o++) outRf[o] <= outDefault;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (strobes.outEn[l]) outRf[oSel][l*DATA_W +: DATA_W] <= outSrc[l*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    if (int'(tempRdIdx) < NUM_TEMP)       tempRdData = tempRf[tempRdIdx[TSEL_W-1:0]];
    else if (int'(tempRdIdx) == POS_ALIAS) tempRdData = outRf[0];
    else                                   tempRdData = '0;
  end

  always_comb begin
    if (int'(outRdIdx) < NUM_OUT) outRdData = outRf[outRdIdx[OSEL_W-1:0]];
    else                          outRdData = '0;
  end

  assign posOut = outRf[0];
endmodule

// File: rtl/vswb_top.sv
module vswb_top
  import vswb_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          NUM_TEMP  = 12,
  parameter int          NUM_OUT   = 13,
  parameter int          TIDX_W    = 4,
  parameter int          OIDX_W    = 8,
  parameter logic [31:0] ONE_VALUE = 32'h3F80_0000,
  localparam int         VEC_W     = LANES * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vertexStart,
  input  logic [VEC_W-1:0]  macResult,
  input  logic [VEC_W-1:0]  iluResult,
  input  logic [LANES-1:0]  macMask,
  input  logic [LANES-1:0]  iluMask,
  input  logic [TIDX_W-1:0] tempIdx,
  input  logic [LANES-1:0]  overallMask,
  input  logic              destSel,
  input  logic              destMux,
  input  logic [OIDX_W-1:0] outIdx,
  input  logic [TIDX_W-1:0] tempRdIdx,
  output logic [VEC_W-1:0]  tempRdData,
  input  logic [OIDX_W-1:0] outRdIdx,
  output logic [VEC_W-1:0]  outRdData,
  output logic [VEC_W-1:0]  posOut
);
  wbStrobes_t strobes;

  vswb_ctrl #(
    .NUM_TEMP(NUM_TEMP), .NUM_OUT(NUM_OUT), .TIDX_W(TIDX_W), .OIDX_W(OIDX_W)
  ) u_ctrl (
    .vertexStart(vertexStart), .macMask(macMask), .iluMask(iluMask),
    .tempIdx(tempIdx), .overallMask(overallMask), .destSel(destSel),
    .destMux(destMux), .outIdx(outIdx), .strobes(strobes)
  );

  vswb_datapath #(
    .DATA_W(DATA_W), .NUM_TEMP(NUM_TEMP), .NUM_OUT(NUM_OUT),
    .TIDX_W(TIDX_W), .OIDX_W(OIDX_W), .ONE_VALUE(ONE_VALUE)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .macResult(macResult), .iluResult(iluResult),
    .tempIdx(tempIdx), .outIdx(outIdx),
    .tempRdIdx(tempRdIdx), .tempRdData(tempRdData),
    .outRdIdx(outRdIdx), .outRdData(outRdData), .posOut(posOut)
  );
endmodule

// File: rtl/vswb_checker.sv
module vswb_checker #(
  parameter int          DATA_W    = 32,
  parameter int          NUM_TEMP  = 12,
  parameter int          NUM_OUT   = 13,
  parameter int          TIDX_W    = 4,
  parameter int          OIDX_W    = 8,
  parameter logic [31:0] ONE_VALUE = 32'h3F80_0000,
  localparam int         VEC_W     = 4 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              vertexStart,
  input logic [VEC_W-1:0]  macResult,
  input logic [VEC_W-1:0]  iluResult,
  input logic [3:0]        macMask,
  input logic [3:0]        iluMask,
  input logic [3:0]        overallMask,
  input logic              destSel,
  input logic              destMux,
  input logic [OIDX_W-1:0] outIdx,
  input logic [TIDX_W-1:0] tempRdIdx,
  input logic [VEC_W-1:0]  tempRdData,
  input logic [VEC_W-1:0]  posOut
);
  logic [VEC_W-1:0] expDefault;
  assign expDefault = {{(3*DATA_W){1'b0}}, DATA_W'(ONE_VALUE)};

  logic posWrite;
  assign posWrite = destSel && (outIdx == '0) && !vertexStart;

  // R8: a start strobe leaves every output lane at its default
  p_start_clear_r8: assert property (@(posedge clk) disable iff (rst)
    vertexStart |=> (posOut == expDefault));

  // R6: without the select bit the position register holds
  p_no_select_r6: assert property (@(posedge clk) disable iff (rst)
    (!destSel && !vertexStart) |=> $stable(posOut));

  // R7: out-of-range output indices leave the position register alone
  p_out_range_r7: assert property (@(posedge clk) disable iff (rst)
    (destSel && (int'(outIdx) >= NUM_OUT) && !vertexStart) |=> $stable(posOut));

  // R9: the temporary alias index reads the position register
  p_pos_alias_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(tempRdIdx) == NUM_TEMP) |-> (tempRdData == posOut));

  generate
    for (genvar l = 0; l < 4; l++) begin : g_lane
      // R5: lanes outside the combined mask keep their value
      p_lane_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (posWrite && !(overallMask[l] && (destMux ? iluMask[l] : macMask[l])))
        |=> (posOut[l*DATA_W +: DATA_W] == $past(posOut[l*DATA_W +: DATA_W])));

      // R5: lanes inside the combined mask take the chosen unit's lane
      p_lane_write_r5: assert property (@(posedge clk) disable iff (rst)
        (posWrite && overallMask[l] && (destMux ? iluMask[l] : macMask[l]))
        |=> (posOut[l*DATA_W +: DATA_W] ==
             $past(destMux ? iluResult[l*DATA_W +: DATA_W] : macResult[l*DATA_W +: DATA_W])));
    end
  endgenerate
endmodule

bind vswb_top vswb_checker #(
  .DATA_W(DATA_W), .NUM_TEMP(NUM_TEMP), .NUM_OUT(NUM_OUT),
  .TIDX_W(TIDX_W), .OIDX_W(OIDX_W), .ONE_VALUE(ONE_VALUE)
) u_chk (
  .clk(clk), .rst(rst), .vertexStart(vertexStart),
  .macResult(macResult), .iluResult(iluResult),
  .macMask(macMask), .iluMask(iluMask), .overallMask(overallMask),
  .destSel(destSel), .destMux(destMux), .outIdx(outIdx),
  .tempRdIdx(tempRdIdx), .tempRdData(tempRdData), .posOut(posOut)
);

// File: tb/vswb_top_tb.sv
`timescale 1ns/1ps
module vswb_top_tb;
  localparam int NT = 12;
  localparam int NO = 13;
  localparam logic [127:0] DEF = {96'h0, 32'h3F80_0000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vertexStart = 1'b0;
  logic [127:0] macResult = '0, iluResult = '0;
  logic [3:0] macMask = '0, iluMask = '0, tempIdx = '0, overallMask = '0;
  logic destSel = 1'b0, destMux = 1'b0;
  logic [7:0] outIdx = '0;
  logic [3:0] tempRdIdx = '0;
  logic [7:0] outRdIdx = '0;
  logic [127:0] tempRdData, outRdData, posOut;

  int checks = 0;
  int fails = 0;

  logic [127:0] mTemp [NT];
  logic [127:0] mOut  [NO];

  always #2.5 clk = ~clk;

  vswb_top u_dut (
    .clk(clk), .rst(rst), .vertexStart(vertexStart),
    .macResult(macResult), .iluResult(iluResult),
    .macMask(macMask), .iluMask(iluMask), .tempIdx(tempIdx),
    .overallMask(overallMask), .destSel(destSel), .destMux(destMux),
    .outIdx(outIdx), .tempRdIdx(tempRdIdx), .tempRdData(tempRdData),
    .outRdIdx(outRdIdx), .outRdData(outRdData), .posOut(posOut)
  );

  typedef struct packed {
    logic [3:0] macM;
    logic [3:0] iluM;
    logic [3:0] ovM;
    logic [3:0] tIdx;
    logic       sel;
    logic       mux;
    logic [7:0] oIdx;
    logic       start;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 4'b0000, 4'b0000, 4'd0,  1'b0, 1'b0, 8'd0,   1'b0}, // R3 full MAC
    '{4'b1100, 4'b0011, 4'b0000, 4'd1,  1'b0, 1'b0, 8'd0,   1'b0}, // R3 R4 disjoint
    '{4'b1111, 4'b1111, 4'b0000, 4'd2,  1'b0, 1'b0, 8'd0,   1'b0}, // R4 full overlap
    '{4'b1010, 4'b0110, 4'b0000, 4'd11, 1'b0, 1'b0, 8'd0,   1'b0}, // R4 partial overlap
    '{4'b1000, 4'b0000, 4'b1111, 4'd3,  1'b1, 1'b0, 8'd0,   1'b0}, // R2 X only
    '{4'b0001, 4'b0000, 4'b1111, 4'd4,  1'b1, 1'b0, 8'd5,   1'b0}, // R2 W only
    '{4'b1111, 4'b0101, 4'b0011, 4'd5,  1'b1, 1'b1, 8'd7,   1'b0}, // R5 ILU narrow overall
    '{4'b0110, 4'b1111, 4'b1111, 4'd6,  1'b1, 1'b0, 8'd12,  1'b0}, // R5 MAC, last output
    '{4'b1111, 4'b1111, 4'b1111, 4'd7,  1'b0, 1'b1, 8'd7,   1'b0}, // R6 select off
    '{4'b1111, 4'b1111, 4'b1111, 4'd8,  1'b1, 1'b1, 8'd13,  1'b0}, // R7 first bad index
    '{4'b1111, 4'b1111, 4'b1111, 4'd12, 1'b1, 1'b1, 8'd200, 1'b0}, // R7 R10 both bad
    '{4'b1111, 4'b0000, 4'b1111, 4'd9,  1'b1, 1'b0, 8'd3,   1'b1}  // R8 start wins
  };

  function automatic logic [127:0] macVal(int n);
    return {32'h1100_0000 + n, 32'h2200_0000 + n, 32'h3300_0000 + n, 32'h4400_0000 + n};
  endfunction
  function automatic logic [127:0] iluVal(int n);
    return {32'h5500_0000 + n, 32'h6600_0000 + n, 32'h7700_0000 + n, 32'h8800_0000 + n};
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply one write cycle and update the reference model after the edge
  task automatic doWrite(vec_t v, logic [127:0] m, logic [127:0] i);
    @(negedge clk);
    macResult = m; iluResult = i;
    macMask = v.macM; iluMask = v.iluM; overallMask = v.ovM;
    tempIdx = v.tIdx; destSel = v.sel; destMux = v.mux;
    outIdx = v.oIdx; vertexStart = v.start;
    @(posedge clk);
    if (int'(v.tIdx) < NT) begin
      for (int l = 0; l < 4; l++) if (v.macM[l]) mTemp[v.tIdx][l*32 +: 32] = m[l*32 +: 32];
      for (int l = 0; l < 4; l++) if (v.iluM[l]) mTemp[v.tIdx][l*32 +: 32] = i[l*32 +: 32];
    end
    if (v.start) begin
      for (int o = 0; o < NO; o++) mOut[o] = DEF;
    end else if (v.sel && int'(v.oIdx) < NO) begin
      for (int l = 0; l < 4; l++)
        if (v.ovM[l] && (v.mux ? v.iluM[l] : v.macM[l]))
          mOut[v.oIdx][l*32 +: 32] = v.mux ? i[l*32 +: 32] : m[l*32 +: 32];
    end
    @(negedge clk);
    macMask = '0; iluMask = '0; overallMask = '0; destSel = 1'b0; vertexStart = 1'b0;
  endtask

  task automatic checkAll(string tag);
    for (int t = 0; t < 16; t++) begin
      tempRdIdx = 4'(t);
      #0.5;
      check(tag, tempRdData, (t < NT) ? mTemp[t] : (t == NT) ? mOut[0] : 128'h0);
    end
    for (int o = 0; o < 16; o++) begin
      outRdIdx = 8'(o);
      #0.5;
      check(tag, outRdData, (o < NO) ? mOut[o] : 128'h0);
    end
  endtask

  task automatic finishRun();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    vec_t v;
    for (int t = 0; t < NT; t++) mTemp[t] = '0;
    for (int o = 0; o < NO; o++) mOut[o] = DEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset contents
    checkAll("R1 reset state");
    check("R1 position default", posOut, DEF);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < NV; k++) begin
      doWrite(VECS[k], macVal(k), iluVal(k));
      checkAll($sformatf("R2 R3 R4 R5 R6 R7 R8 R10 vector %0d", k));
    end

    // R2: single X lane lands in bits 127:96 only
    v = '{4'b1000, 4'b0000, 4'b0000, 4'd10, 1'b0, 1'b0, 8'd0, 1'b0};
    mTemp[10] = mTemp[10];
    doWrite(v, {32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003, 32'hCAFE_0004}, '0);
    tempRdIdx = 4'd10; #0.5;
    check("R2 X lane", tempRdData[127:96], 32'hCAFE_0001);
    check("R2 other lanes kept", tempRdData[95:0], 96'h0);

    // R9 and R11: position write, same-cycle read shows old, next cycle new
    v = '{4'b1111, 4'b0000, 4'b1111, 4'd0, 1'b1, 1'b0, 8'd0, 1'b0};
    @(negedge clk);
    macResult = {32'hA1, 32'hA2, 32'hA3, 32'hA4};
    macMask = 4'b1111; overallMask = 4'b1111; tempIdx = 4'd0;
    destSel = 1'b1; destMux = 1'b0; outIdx = 8'd0;
    tempRdIdx = 4'd12; #0.5;
    check("R11 old value before edge", tempRdData, mOut[0]);
    @(posedge clk); #0.5;
    check("R9 alias after write", tempRdData, {32'hA1, 32'hA2, 32'hA3, 32'hA4});
    check("R9 position port", posOut, {32'hA1, 32'hA2, 32'hA3, 32'hA4});
    mOut[0] = {32'hA1, 32'hA2, 32'hA3, 32'hA4};
    mTemp[0] = {32'hA1, 32'hA2, 32'hA3, 32'hA4};
    @(negedge clk);
    macMask = '0; overallMask = '0; destSel = 1'b0;

    // R8: start with concurrent output write; temporary write still lands
    v = '{4'b0000, 4'b1111, 4'b1111, 4'd4, 1'b1, 1'b1, 8'd0, 1'b1};
    doWrite(v, '0, {32'hBB, 32'hBC, 32'hBD, 32'hBE});
    check("R8 position back to default", posOut, DEF);
    tempRdIdx = 4'd4; #0.5;
    check("R8 temporary written", tempRdData, {32'hBB, 32'hBC, 32'hBD, 32'hBE});
    checkAll("R8 R10 after start");

    // R10: write to temporary 13 leaves all temporaries
    v = '{4'b1111, 4'b1111, 4'b0000, 4'd13, 1'b0, 1'b0, 8'd0, 1'b0};
    doWrite(v, macVal(99), iluVal(99));
    checkAll("R10 temp index 13");

    finishRun();
  end
endmodule